// File: doc/BRIEF.md
# Third-Order Noise-Shaped Pulse-Length Converter

This block turns an oversampled stream of unsigned multi-bit samples into a one-bit pulse train. The pulse train is meant to be smoothed by a simple low-order analog low-pass filter. Samples come from an upstream interpolation filter. They are first re-registered on the local master clock, so that any timing wander on the data path stays out of the conversion.

The converter works in frames of 2^LEVEL_W master clocks (8 by default). At each frame boundary, one retimed sample is taken. A third-order error-feedback loop requantizes it to one of 2^LEVEL_W + 1 levels (0 to 8). The loop's noise transfer is (1 - z^-1)^3, which pushes the requantization noise up towards high frequencies. During the next frame the output goes high for exactly as many clocks as the chosen level, always starting at the first clock of the frame.

If no valid sample is present at a boundary, the block feeds mid-scale into the loop. The shaped value is clamped before rounding. This keeps every stored error small and stops the loop state from growing without bound.

Top module: `shaped_pulse_dac`

## Requirements
- R1: While reset is high, pulse_o is 0. The frame that follows the first clock edge after reset carries mid-scale level 4, which gives 4 high clocks.
- R2: Every frame lasts 8 clocks. pulse_o is high for exactly `level` consecutive clocks starting at the frame's first clock, and low for the rest of the frame. A rising edge of pulse_o can only occur at a frame start.
- R3: The level is always between 0 and 8. Level 0 gives a frame that stays low throughout. Level 8 gives a frame that stays high throughout.
- R4: sample_i and sample_valid_i pass through one retiming register. A value that first appears in the last clock before a boundary is not used at that boundary; the value held during the clock before it is used instead.
- R5: With S = 2^(SAMPLE_W-3), the sample is unsigned, and level k corresponds to sample value k*S. The shaped value is y = x - 3*e[n-1] + 3*e[n-2] - e[n-3], where e = level*S - y_clamped is the stored error of each past frame.
- R6: Before rounding, y is clamped to the range [-S/2, 8.5*S - 1]. The level is then floor((y_clamped + S/2) / S).
- R7: If the retimed valid is low at a boundary, x is taken as mid-scale, 4*S.
- R8: The valid input is looked at only at frame boundaries. A valid pulse that has dropped before the boundary register stage has no effect, and mid-scale is used instead.
- R9: While the stored errors are zero, a steady input of exactly k*S gives level k in every frame.
- R10: For a steady input of 4.3*S held over 64 frames, the total of the output levels times S differs from 64*x by at most 4*S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | SAMPLE_W | Unsigned oversampled sample from the filter |
| sample_valid_i | input | 1 | Sample qualifier |
| pulse_o | output | 1 | Pulse-length-modulated one-bit output |

## Verification
A wrong error register or a wrong feedback coefficient does not change the frame shape. It changes which level comes out, and that difference first shows up in the frame after the faulty update, as a pulse that is one or more clocks too long or too short. A broken frame counter or level register shows up within one frame, as a pulse that is not contiguous, starts late, or exceeds the frame. Drift in the loop state builds up slowly, so it is caught by comparing the long-run average of the levels against the input.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_LEVEL_W  = 3;
    localparam int SHAPE_ORDER  = 3;

    typedef enum logic [0:0] {
        SRC_MIDSCALE = 1'b0,
        SRC_INPUT    = 1'b1
    } src_sel_e;

    function automatic int frame_cycles(input int lvl_w);
        return 1 << lvl_w;
    endfunction
endpackage

// File: rtl/spd_retime.sv
module spd_retime #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    input  logic         v_i,
    output logic [W-1:0] d_o,
    output logic         v_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_o <= '0;
            v_o <= 1'b0;
        end else begin
            d_o <= d_i;
            v_o <= v_i;
        end
    end
endmodule

// File: rtl/spd_shaper.sv
module spd_shaper
    import spd_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  src_sel_e         src_i,
    input  logic [IN_W-1:0]  x_i,
    output logic [LVL_W:0]   level_o
);
    localparam int SH    = IN_W - LVL_W;
    localparam int ACC_W = IN_W + 3;
    localparam int FRAME = frame_cycles(LVL_W);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (SH - 1));
    localparam logic signed [ACC_W-1:0] MID  = ACC_W'(2 ** (IN_W - 1));
    localparam logic signed [ACC_W-1:0] Y_LO = ACC_W'(-(2 ** (SH - 1)));
    localparam logic signed [ACC_W-1:0] Y_HI = ACC_W'(FRAME * (2 ** SH) + 2 ** (SH - 1) - 1);

    logic signed [ACC_W-1:0] err_q [SHAPE_ORDER];
    logic signed [ACC_W-1:0] x_ext, fb, y_raw, y_cl, err_new;
    logic        [IN_W:0]    sum_u;
    logic        [SH-1:0]    resid;

    always_comb begin
        x_ext = (src_i == SRC_INPUT) ? signed'({{(ACC_W-IN_W){1'b0}}, x_i}) : MID;
        fb    = ((err_q[1] <<< 1) + err_q[1]) - ((err_q[0] <<< 1) + err_q[0]) - err_q[2];
        y_raw = x_ext + fb;
        if (y_raw < Y_LO)      y_cl = Y_LO;
        else if (y_raw > Y_HI) y_cl = Y_HI;
        else                   y_cl = y_raw;
        sum_u   = (IN_W+1)'(y_cl + HALF);
        level_o = sum_u[IN_W:SH];
        resid   = sum_u[SH-1:0];
        err_new = HALF - signed'({{(ACC_W-SH){1'b0}}, resid});
    end

    generate
        for (genvar t = 0; t < SHAPE_ORDER; t++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) begin
                    err_q[t] <= '0;
                end else if (take_i) begin
                    if (t == 0) err_q[t] <= err_new;
                    else        err_q[t] <= err_q[(t == 0) ? 0 : t-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/spd_pulse.sv
module spd_pulse
    import spd_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W:0]   level_i,
    output logic             bound_o,
    output logic [LVL_W-1:0] cnt_o,
    output logic [LVL_W:0]   level_o,
    output logic             pulse_o
);
    logic [LVL_W-1:0] nxt_cnt;
    logic [LVL_W:0]   nxt_lvl;

    always_comb begin
        bound_o = (cnt_o == '1);
        nxt_cnt = cnt_o + 1'b1;
        nxt_lvl = bound_o ? level_i : level_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o   <= '1;
            level_o <= '0;
            pulse_o <= 1'b0;
        end else begin
            cnt_o   <= nxt_cnt;
            level_o <= nxt_lvl;
            pulse_o <= ({1'b0, nxt_cnt} < nxt_lvl);
        end
    end
endmodule

// File: rtl/shaped_pulse_dac.sv
module shaped_pulse_dac
    import spd_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int LEVEL_W  = DEF_LEVEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_valid_i,
    output logic                pulse_o
);
    logic [SAMPLE_W-1:0] rt_data;
    logic                rt_valid;
    logic                frm_bound;
    logic [LEVEL_W:0]    new_level;
    logic [LEVEL_W:0]    cur_level;
    logic [LEVEL_W-1:0]  frm_cnt;
    src_sel_e            src_sel;

    assign src_sel = rt_valid ? SRC_INPUT : SRC_MIDSCALE;

    spd_retime #(.W(SAMPLE_W)) u_retime (
        .clk(clk), .rst(rst),
        .d_i(sample_i), .v_i(sample_valid_i),
        .d_o(rt_data),  .v_o(rt_valid)
    );

    spd_shaper #(.IN_W(SAMPLE_W), .LVL_W(LEVEL_W)) u_shaper (
        .clk(clk), .rst(rst),
        .take_i(frm_bound), .src_i(src_sel), .x_i(rt_data),
        .level_o(new_level)
    );

    spd_pulse #(.LVL_W(LEVEL_W)) u_pulse (
        .clk(clk), .rst(rst),
        .level_i(new_level), .bound_o(frm_bound),
        .cnt_o(frm_cnt), .level_o(cur_level), .pulse_o(pulse_o)
    );
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
    parameter int LEVEL_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               pulse_o,
    input logic [LEVEL_W-1:0] frm_cnt,
    input logic [LEVEL_W:0]   cur_level
);
    localparam int FRAME = 1 << LEVEL_W;

    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> (frm_cnt == '0));

    a_r2_level_held: assert property (@(posedge clk) disable iff (rst)
        (frm_cnt != '0) |-> $stable(cur_level));

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (frm_cnt != LEVEL_W'(FRAME - 1)) |=> (frm_cnt == $past(frm_cnt) + 1'b1));

    a_r3_level_range: assert property (@(posedge clk) disable iff (rst)
        cur_level <= (LEVEL_W+1)'(FRAME));

    a_r3_full_frame: assert property (@(posedge clk) disable iff (rst)
        (cur_level == (LEVEL_W+1)'(FRAME)) |-> pulse_o);

    a_r3_empty_frame: assert property (@(posedge clk) disable iff (rst)
        (cur_level == '0) |-> !pulse_o);
endmodule

bind shaped_pulse_dac spd_checker #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk(clk), .rst(rst), .pulse_o(pulse_o),
    .frm_cnt(frm_cnt), .cur_level(cur_level)
);

// File: tb/shaped_pulse_dac_test.sv
module shaped_pulse_dac_test;
    localparam int W    = 16;
    localparam int LW   = 3;
    localparam int FR   = 1 << LW;
    localparam int S    = 1 << (W - LW);
    localparam int HALF = S / 2;
    localparam int NT   = 8;
    localparam int TX [NT] = '{3*S, 0, 7*S, S, 5*S, 2*S, 6*S, 4*S};
    localparam bit TV [NT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam int TE [NT] = '{3, 0, 7, 1, 4, 2, 6, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] din = '0;
    logic vin = 1'b0;
    logic pulse;
    bit done = 1'b0;

    int total = 0;
    int bad = 0;
    int e1 = 0, e2 = 0, e3 = 0;
    int exp_next = 0;

    always #4 clk = ~clk;

    shaped_pulse_dac #(.SAMPLE_W(W), .LEVEL_W(LW)) uut (
        .clk(clk), .rst(rst), .sample_i(din),
        .sample_valid_i(vin), .pulse_o(pulse)
    );

    // Reference arithmetic from R5, R6 and R7
    task automatic mstep(input int x, input bit v, output int q);
        int xs, y, e;
        xs = v ? x : 4 * S;
        y  = xs - 3 * e1 + 3 * e2 - e3;
        if (y < -HALF) y = -HALF;
        if (y > FR * S + HALF - 1) y = FR * S + HALF - 1;
        q  = (y + HALF) / S;
        e  = q * S - y;
        e3 = e2; e2 = e1; e1 = e;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Applies one sample for a frame and checks the frame carrying the previous one.
    task automatic frame(input int x, input bit v, input int drop_at, input int alt,
                         input int want, input string req, output int seen);
        logic [FR-1:0] pat;
        int lvl;
        bit eff_v;
        din = W'(x);
        vin = v;
        eff_v = v;
        for (int i = 0; i < FR; i++) begin
            @(negedge clk);
            pat[i] = pulse;
            if (i == drop_at) begin
                vin = 1'b0;
                eff_v = 1'b0;
            end
        end
        if (alt >= 0) din = W'(alt);
        lvl = (want >= 0) ? want : exp_next;
        seen = $countones(pat);
        check(pat == FR'((1 << lvl) - 1), req, int'(pat), (1 << lvl) - 1);
        mstep(x, eff_v, exp_next);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen, sum, x;
        bit saw_full;
        repeat (3) @(negedge clk);
        check(pulse == 1'b0, "R1 reset low", int'(pulse), 0);
        rst = 1'b0;
        mstep(0, 1'b0, exp_next);

        // Table walk: exact levels keep errors at zero (R9), invalid gives mid-scale (R7)
        for (int i = 0; i < NT; i++) begin
            frame(TX[i], TV[i], -1, -1, (i == 0) ? 4 : TE[i-1],
                  (i == 0) ? "R1 first frame midscale" : "R9 exact level table", seen);
        end
        // R8: valid dropped mid-frame is ignored, mid-scale expected next
        frame(7 * S, 1'b1, 2, -1, TE[NT-1], "R9 table last", seen);
        // R4: late change to 6S is not taken at this boundary
        frame(2 * S, 1'b1, -1, 6 * S, 4, "R8 valid dropped before boundary", seen);
        frame(6 * S, 1'b1, -1, -1, 2, "R4 retimed value used", seen);
        frame(0, 1'b1, -1, -1, 6, "R4 held value next frame", seen);
        // R3: empty frame
        frame(8 * S - 1, 1'b1, -1, -1, 0, "R3 level zero empty", seen);
        check(seen == 0, "R3 zero high count", seen, 0);

        // R3/R6: full scale drives level 8 then clamp and feedback pull it back
        saw_full = 1'b0;
        for (int i = 0; i < 20; i++) begin
            frame(8 * S - 1, 1'b1, -1, -1, -1, "R6 full scale clamp", seen);
            if (seen == FR) saw_full = 1'b1;
        end
        check(saw_full, "R3 full frame seen", int'(saw_full), 1);

        // R5: ramp across the range, frame by frame against the reference
        for (int i = 0; i < 40; i++) begin
            frame((i * (8 * S - 1)) / 39, 1'b1, -1, -1, -1, "R5 ramp shaping", seen);
        end

        // R10: long-run average of a steady non-integer level
        x = 4 * S + (3 * S) / 10;
        frame(x, 1'b1, -1, -1, -1, "R5 dc lead-in", seen);
        sum = 0;
        for (int i = 0; i < 64; i++) begin
            frame(x, 1'b1, -1, -1, -1, "R5 dc shaping", seen);
            sum += seen;
        end
        check((sum * S - 64 * x) <= 4 * S && (64 * x - sum * S) <= 4 * S,
              "R10 dc average", sum * S, 64 * x);

        // R7: idle input falls back to mid-scale around the loop
        for (int i = 0; i < 6; i++) begin
            frame(0, 1'b0, -1, -1, -1, "R7 no valid midscale", seen);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule